// File: doc/BRIEF.md
# Reload Down-Counter Timer

A small peripheral timer on a plain 32-bit register bus. Software writes a 16-bit reload value, which also loads the live count at once. It then sets an enable bit, and the count starts falling by one on every timebase tick. A prescaler divides the system clock by `CLK_DIV` to make the 1 MHz tick. When the count reaches zero, the next tick copies the reload value back in, so the timer repeats with a period of reload+1 ticks.

Only two things stop the counter: a hardware reset, or a control write with the soft-reset bit set. Clearing the enable bit stores the new control word and leaves a running counter running. The register window is 256 bytes and takes word accesses only. A read returns data in the same cycle that the bus request is valid.

Top module: `tick_reload_timer`

## Requirements
- R1: While `rst` is high and after it falls, the control, reload and count registers read 0 and the counter is stopped.
- R2: Word offsets are control 0x00, reload 0x08 and count 0x0C. Any other address in the 8-bit window, including one with bits 1:0 nonzero, reads 0 and ignores writes.
- R3: A control write with bit 31 set stops the counter and clears control, reload and count to 0. None of the other bits in that word is stored.
- R4: A control write with bit 31 clear stores the whole 32-bit word. If bit 0 is also set, the counter starts running.
- R5: A control write with bit 0 clear and bit 31 clear does not stop a running counter.
- R6: A reload write keeps only bits 15:0. It stores them and loads the count with them on the same clock edge, and this load takes priority over a tick on that edge.
- R7: A count read returns the count in bits 15:0 with bits 31:16 zero. A write to the count offset changes nothing.
- R8: While running, a tick occurs every `CLK_DIV` clocks. The first tick takes effect on the edge `CLK_DIV` clocks after the start write. While stopped, the count holds and the prescaler stays cleared.
- R9: Each tick decrements a nonzero count by one. A tick on a zero count reloads it from the reload register, so a reload value of 0 holds the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_valid | input | 1 | Bus request valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read request, 0 otherwise |

## Verification
A table of reload values and tick counts drives the countdown. Its entries cover zero ticks, a partial countdown, an exact wrap back to the reload value, several full periods, reload 1, reload 0 and the 16-bit maximum. Between them, these entries separate plain decrementing, the reload-at-zero step, and a wrong period (an off-by-one in the reload step would show up as a count shifted by one). Directed sequences then check a few corner cases: clearing the enable bit mid-run, where the count must keep falling on the original tick phase; a reload write during a run, which must show up at once; soft reset after a control write with extra bits set, where none of those bits may be kept; and writes to the count, the gap and unaligned offsets, which must leave every register as it was.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_RELOAD = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h0C;

  localparam int BIT_SOFTRST = 31;
  localparam int BIT_ENABLE  = 0;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_RELOAD,
    SEL_COUNT
  } reg_sel_e;

  // Word accesses only: any offset with low bits set is unmapped.
  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_e s;
    s = SEL_NONE;
    if (a[1:0] == 2'b00) begin
      case (a)
        OFF_CTRL:   s = SEL_CTRL;
        OFF_RELOAD: s = SEL_RELOAD;
        OFF_COUNT:  s = SEL_COUNT;
        default:    s = SEL_NONE;
      endcase
    end
    return s;
  endfunction

  // Count value after one tick.
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rel);
    return (cur == '0) ? rel : cur - 1'b1;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count_i,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              run_o,
  output logic              soft_clr_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [CNT_W-1:0]  reload_o
);
  reg_sel_e          sel;
  logic              wr_en;
  logic              ctrl_wr;
  logic              start_ev;
  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic              run_q;

  assign sel        = decode_addr(bus_addr);
  assign wr_en      = bus_valid && bus_write;
  assign ctrl_wr    = wr_en && (sel == SEL_CTRL);
  assign soft_clr_o = ctrl_wr && bus_wdata[BIT_SOFTRST];
  assign start_ev   = ctrl_wr && !bus_wdata[BIT_SOFTRST] && bus_wdata[BIT_ENABLE];
  assign load_o     = wr_en && (sel == SEL_RELOAD) && !soft_clr_o;
  assign load_val_o = bus_wdata[CNT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || soft_clr_o) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      run_q    <= 1'b0;
    end else begin
      if (ctrl_wr)  ctrl_q   <= bus_wdata;
      if (start_ev) run_q    <= 1'b1;
      if (load_o)   reload_q <= load_val_o;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write) begin
      case (sel)
        SEL_CTRL:   bus_rdata = ctrl_q;
        SEL_RELOAD: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, reload_q};
        SEL_COUNT:  bus_rdata = {{(DATA_W-CNT_W){1'b0}}, count_i};
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign run_o    = run_q;
  assign reload_o = reload_q;

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    soft_clr_o |=> (ctrl_q == '0) && (reload_q == '0) && !run_q) else $error("soft clear"); // R3
  AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    run_q && !soft_clr_o |=> run_q) else $error("run dropped"); // R5
  AST_CTRL_STORED: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr && !bus_wdata[BIT_SOFTRST] |=> ctrl_q == $past(bus_wdata)) else $error("ctrl store"); // R4
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = run_i && !clr_i;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] presc_q;

      always_ff @(posedge clk) begin
        if (rst || !run_i || clr_i) presc_q <= '0;
        else if (presc_q == LAST)   presc_q <= '0;
        else                        presc_q <= presc_q + 1'b1;
      end

      assign tick_o = run_i && (presc_q == LAST);

      AST_START_PHASE: assert property (@(posedge clk) disable iff (rst)
        $rose(run_i) |-> presc_q == '0) else $error("phase"); // R8
      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o) else $error("spacing"); // R8
    end
  endgenerate
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)  cnt_q <= '0;
    else if (load_i)   cnt_q <= load_val_i;
    else if (tick_i)   cnt_q <= step_count(cnt_q, reload_i);
  end

  assign count_o = cnt_q;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick_i && !load_i && !clr_i |=> $stable(cnt_q)) else $error("hold"); // R8
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    tick_i && !load_i && !clr_i && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1) else $error("dec"); // R9
  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    tick_i && !load_i && !clr_i && (cnt_q == '0) |=> cnt_q == $past(reload_i)) else $error("wrap"); // R9
  AST_LOAD_NOW: assert property (@(posedge clk) disable iff (rst)
    load_i && !clr_i |=> cnt_q == $past(load_val_i)) else $error("load"); // R6
endmodule

// File: rtl/tick_reload_timer.sv
module tick_reload_timer
  import tmr_pkg::*;
#(
  parameter int CLK_DIV = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  logic             run;
  logic             soft_clr;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] count;
  logic             tick;

  tmr_regs u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .count_i    (count),
    .bus_rdata  (bus_rdata),
    .run_o      (run),
    .soft_clr_o (soft_clr),
    .load_o     (load),
    .load_val_o (load_val),
    .reload_o   (reload)
  );

  tmr_prescaler #(.DIV(CLK_DIV)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .run_i  (run),
    .clr_i  (soft_clr),
    .tick_o (tick)
  );

  tmr_counter u_cnt (
    .clk        (clk),
    .rst        (rst),
    .clr_i      (soft_clr),
    .load_i     (load),
    .load_val_i (load_val),
    .tick_i     (tick),
    .reload_i   (reload),
    .count_o    (count)
  );

  AST_STOPPED_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !run |-> !tick) else $error("tick while stopped"); // R8
endmodule

// File: tb/tick_reload_timer_tb_top.sv
module tick_reload_timer_tb_top;
  localparam int DIV = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tick_reload_timer #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // {reload, ticks, expected count}
  localparam logic [47:0] VEC [0:6] = '{
    {16'd2,     16'd0, 16'd2},
    {16'd5,     16'd3, 16'd2},
    {16'd5,     16'd6, 16'd5},
    {16'd3,     16'd9, 16'd2},
    {16'd1,     16'd3, 16'd0},
    {16'd0,     16'd4, 16'd0},
    {16'hFFFF,  16'd2, 16'hFFFD}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #2;
    rd(8'h00, v); chk("R1 ctrl after reset", v, 32'h0);
    rd(8'h08, v); chk("R1 reload after reset", v, 32'h0);
    rd(8'h0C, v); chk("R1 count after reset", v, 32'h0);

    // R9 / R8 table walk: count after n ticks = R - (n mod (R+1))
    for (int i = 0; i < 7; i++) begin
      wr(8'h00, 32'h8000_0000);
      wr(8'h08, {16'h0, VEC[i][47:32]});
      wr(8'h00, 32'h0000_0001);
      wait_edges(int'(VEC[i][31:16]) * DIV);
      rd(8'h0C, v);
      chk($sformatf("R9 vector %0d", i), v, {16'h0, VEC[i][15:0]});
    end

    // R5: clearing enable keeps the counter running on the same phase
    wr(8'h00, 32'h8000_0000);
    wr(8'h08, 32'd10);
    wr(8'h00, 32'h0000_0001);
    wait_edges(2 * DIV);
    rd(8'h0C, v); chk("R8 two ticks", v, 32'd8);
    wr(8'h00, 32'h0000_0002);
    rd(8'h00, v); chk("R4 ctrl stored whole word", v, 32'h2);
    wait_edges(4 * DIV - 1);
    rd(8'h0C, v); chk("R5 still running", v, 32'd4);

    // R6: reload write while running loads at once, upper bits dropped
    wr(8'h08, 32'hABCD_0014);
    rd(8'h0C, v); chk("R6 immediate load", v, 32'd20);
    rd(8'h08, v); chk("R6 reload low half only", v, 32'h14);

    // R4 store, then R3 soft reset discards the word
    wr(8'h00, 32'h1234_5671);
    rd(8'h00, v); chk("R4 ctrl readback", v, 32'h1234_5671);
    wr(8'h00, 32'h8000_0001);
    rd(8'h00, v); chk("R3 ctrl cleared", v, 32'h0);
    rd(8'h08, v); chk("R3 reload cleared", v, 32'h0);
    rd(8'h0C, v); chk("R3 count cleared", v, 32'h0);
    wr(8'h08, 32'd7);
    wait_edges(3 * DIV);
    rd(8'h0C, v); chk("R3 counter stopped", v, 32'd7);

    // R7: count write ignored
    wr(8'h0C, 32'h0000_FFFF);
    rd(8'h0C, v); chk("R7 count write ignored", v, 32'd7);

    // R2: unmapped and unaligned offsets
    wr(8'h00, 32'h0000_0F00);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, v); chk("R2 gap reads zero", v, 32'h0);
    rd(8'h00, v); chk("R2 ctrl untouched", v, 32'h0000_0F00);
    wr(8'h09, 32'h0000_0033);
    rd(8'h08, v); chk("R2 unaligned write ignored", v, 32'd7);
    rd(8'h09, v); chk("R2 unaligned reads zero", v, 32'h0);
    wr(8'h80, 32'h0000_0001);
    wait_edges(2 * DIV);
    rd(8'h0C, v); chk("R2 far write did not start", v, 32'd7);

    // R1: hardware reset mid-run
    wr(8'h00, 32'h0000_0001);
    wait_edges(DIV);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    #1;
    rd(8'h0C, v); chk("R1 count after mid-run reset", v, 32'h0);
    rd(8'h00, v); chk("R1 ctrl after mid-run reset", v, 32'h0);
    wr(8'h08, 32'd4);
    wait_edges(2 * DIV);
    rd(8'h0C, v); chk("R1 stopped after reset", v, 32'd4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule